// File: doc/BRIEF.md
# Two-Way Set-Associative Data Cache

This block is a small read/write data cache between a processor's load/store port and a slower memory. It holds eight 32-bit words as two ways of four sets, one word per line. Each request presents a byte address. Both ways of the indexed set are compared in the same cycle, and the matching word is returned with a hit indication.

A load that misses holds the processor with a stall output. It fetches the word from the lower memory through a request/acknowledge handshake and installs it in a way of the set. If both ways are occupied, the installed word replaces the least recently used one. One use bit per set tracks which way that is.

Stores go through to memory every time. A store that hits also refreshes the cached copy. A store that misses leaves the cache untouched. The processor keeps its request steady while stall is high and takes the result in the first cycle where stall is low.

Top module: `sa2_cache`

## Requirements
- R1: After reset every line is invalid and no memory request is raised. With no request presented, stall stays low, and the first load to any address misses.
- R2: The address is split into three fields. The tag is bits [31:4] and the set index is bits [3:2]. Bits [1:0] are a byte offset that plays no part in lookup, so addresses that differ only there reach the same cached word.
- R3: A load that hits returns the cached word with rsp_hit high and stall low in the same cycle it is presented, and it raises no memory request.
- R4: A load that misses raises stall and mem_rd_req, with mem_addr equal to the request address with bits [1:0] cleared. Both stay high until mem_ack. The returned word is installed on the ack edge and served as a hit in the next cycle (five cycles of stall with a three-cycle memory).
- R5: Two addresses with different tags in the same set, such as 0x04 and 0x24 in set 1, can be resident together. After their first two misses, alternating loads to them all hit.
- R6: Every load hit and every fill makes the set's use bit point at the other way. On a miss with both ways valid, the way the use bit points at is replaced: after 0x04 then 0x24, a load of 0x54 evicts 0x04 and keeps 0x24.
- R7: Every store raises mem_wr_req with mem_addr equal to the request address with bits [1:0] cleared and mem_wdata equal to the store data. Stall is held from the request cycle until the ack cycle and drops in the ack cycle (four cycles with a three-cycle memory).
- R8: A store that hits writes the new word into the matching way and marks that way as most recently used.
- R9: A store that misses allocates nothing, so a later load of that address misses and fetches the stored value from memory.
- R10: Activity in one set leaves the contents of every other set unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Processor access present, held while stall is high |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Store data |
| rsp_rdata | output | 32 | Load data from the hitting way |
| rsp_hit | output | 1 | Lookup hit for the current request |
| stall | output | 1 | Processor must hold its request |
| mem_rd_req | output | 1 | Lower-memory read request |
| mem_wr_req | output | 1 | Lower-memory write request |
| mem_addr | output | 32 | Word-aligned lower-memory address |
| mem_wdata | output | 32 | Lower-memory write data |
| mem_ack | input | 1 | One-cycle completion from lower memory |
| mem_rdata | input | 32 | Read data, valid with mem_ack |

## Verification
In one cycle, a refill and the use-bit update for the same set both land on the acknowledge edge. Likewise, a store-hit data write and its use-bit update share the store's acknowledge edge. The bench provokes these with a conflict pattern in set 1. It loads 0x04 and 0x24, stores to 0x04, and then loads 0x54. The result is judged only at the ports. The bench checks which of the older words still hits, counts memory reads, and confirms that the returned data match the stored value rather than a stale copy.

// File: rtl/sa2_cache_pkg.sv
package sa2_cache_pkg;

  // Number of ways; the replacement scheme (one use bit per set) assumes two.
  localparam int unsigned NUM_WAYS = 2;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FILL  = 2'd1,
    ST_STORE = 2'd2
  } ctrl_state_e;

endpackage

// File: rtl/sa2_cache_way.sv
module sa2_cache_way #(
  parameter int unsigned TAG_W  = 28,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned SETS   = 4,
  localparam int unsigned IDX_W = $clog2(SETS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  lk_idx,
  input  logic [TAG_W-1:0]  lk_tag,
  input  logic              wr_en,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [DATA_W-1:0] wr_data,
  output logic              hit,
  output logic              line_vld,
  output logic [DATA_W-1:0] rdata
);

  logic [SETS-1:0]   vld_q;
  logic [SETS-1:0]   vld_d;
  logic [TAG_W-1:0]  tag_q  [SETS];
  logic [DATA_W-1:0] data_q [SETS];

  always_comb begin
    vld_d = vld_q;
    if (wr_en) vld_d[lk_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else if (wr_en) begin
      vld_q <= vld_d;
    end
  end

  // Tag and data storage carry no reset; the valid bit qualifies them.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[lk_idx]  <= wr_tag;
      data_q[lk_idx] <= wr_data;
    end
  end

  assign line_vld = vld_q[lk_idx];
  assign hit      = line_vld && (tag_q[lk_idx] == lk_tag);
  assign rdata    = data_q[lk_idx];

endmodule

// File: rtl/sa2_cache_lru.sv
module sa2_cache_lru #(
  parameter int unsigned SETS = 4,
  localparam int unsigned IDX_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] lk_idx,
  input  logic             upd_en,
  input  logic             upd_way,
  output logic             lru_way
);

  logic [SETS-1:0] use_q;
  logic [SETS-1:0] use_d;

  // The use bit names the way to replace next: the one not just touched.
  always_comb begin
    use_d = use_q;
    if (upd_en) use_d[lk_idx] = ~upd_way;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      use_q <= '0;
    end else if (upd_en) begin
      use_q <= use_d;
    end
  end

  assign lru_way = use_q[lk_idx];

endmodule

// File: rtl/sa2_cache_ctrl.sv
module sa2_cache_ctrl
  import sa2_cache_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic req_write,
  input  logic hit,
  input  logic mem_ack,
  output logic stall,
  output logic mem_rd_req,
  output logic mem_wr_req,
  output logic fill_en,
  output logic store_upd,
  output logic lookup_upd
);

  ctrl_state_e state_q;
  ctrl_state_e state_d;

  always_comb begin
    state_d    = state_q;
    stall      = 1'b0;
    mem_rd_req = 1'b0;
    mem_wr_req = 1'b0;
    fill_en    = 1'b0;
    store_upd  = 1'b0;
    lookup_upd = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          if (req_write) begin
            stall   = 1'b1;
            state_d = ST_STORE;
          end else if (hit) begin
            lookup_upd = 1'b1;
          end else begin
            stall   = 1'b1;
            state_d = ST_FILL;
          end
        end
      end
      ST_FILL: begin
        stall      = 1'b1;
        mem_rd_req = 1'b1;
        if (mem_ack) begin
          fill_en = 1'b1;
          state_d = ST_IDLE;
        end
      end
      ST_STORE: begin
        mem_wr_req = 1'b1;
        stall      = ~mem_ack;
        if (mem_ack) begin
          store_upd = hit;
          state_d   = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  // R4
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_req && !mem_ack) |=> mem_rd_req);

  // R7
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_req && !mem_ack) |=> mem_wr_req);

endmodule

// File: rtl/sa2_cache.sv
module sa2_cache
  import sa2_cache_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned SETS   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_hit,
  output logic              stall,
  output logic              mem_rd_req,
  output logic              mem_wr_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata
);

  localparam int unsigned OFF_W = $clog2(DATA_W / 8);
  localparam int unsigned IDX_W = $clog2(SETS);
  localparam int unsigned TAG_W = ADDR_W - IDX_W - OFF_W;

  logic [TAG_W-1:0] lk_tag;
  logic [IDX_W-1:0] lk_idx;
  logic             unused_off;

  assign lk_tag     = req_addr[ADDR_W-1 -: TAG_W];
  assign lk_idx     = req_addr[OFF_W +: IDX_W];
  assign unused_off = ^req_addr[OFF_W-1:0];

  logic [NUM_WAYS-1:0] way_hit;
  logic [NUM_WAYS-1:0] way_vld;
  logic [NUM_WAYS-1:0] way_wr;
  logic [DATA_W-1:0]   way_rdata [NUM_WAYS];

  logic              hit;
  logic              hit_way;
  logic              lru_way;
  logic              victim;
  logic              fill_en;
  logic              store_upd;
  logic              lookup_upd;
  logic [DATA_W-1:0] wr_word;

  assign hit     = |way_hit;
  assign hit_way = way_hit[1];
  assign wr_word = fill_en ? mem_rdata : req_wdata;

  // Fill an empty way first (way 0 before way 1), else the LRU way.
  always_comb begin
    if (!way_vld[0])      victim = 1'b0;
    else if (!way_vld[1]) victim = 1'b1;
    else                  victim = lru_way;
  end

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    assign way_wr[w] = (fill_en && (victim == w[0])) ||
                       (store_upd && way_hit[w]);

    sa2_cache_way #(
      .TAG_W (TAG_W),
      .DATA_W(DATA_W),
      .SETS  (SETS)
    ) u_way (
      .clk     (clk),
      .rst_n   (rst_n),
      .lk_idx  (lk_idx),
      .lk_tag  (lk_tag),
      .wr_en   (way_wr[w]),
      .wr_tag  (lk_tag),
      .wr_data (wr_word),
      .hit     (way_hit[w]),
      .line_vld(way_vld[w]),
      .rdata   (way_rdata[w])
    );
  end

  sa2_cache_lru #(
    .SETS(SETS)
  ) u_lru (
    .clk    (clk),
    .rst_n  (rst_n),
    .lk_idx (lk_idx),
    .upd_en (lookup_upd || fill_en || store_upd),
    .upd_way(fill_en ? victim : hit_way),
    .lru_way(lru_way)
  );

  sa2_cache_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .hit       (hit),
    .mem_ack   (mem_ack),
    .stall     (stall),
    .mem_rd_req(mem_rd_req),
    .mem_wr_req(mem_wr_req),
    .fill_en   (fill_en),
    .store_upd (store_upd),
    .lookup_upd(lookup_upd)
  );

  assign rsp_hit   = req_valid && hit;
  assign rsp_rdata = hit_way ? way_rdata[1] : way_rdata[0];
  assign mem_addr  = {lk_tag, lk_idx, {OFF_W{1'b0}}};
  assign mem_wdata = req_wdata;

  // R5
  single_way_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(way_hit));

  // R4
  fill_then_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && req_valid) |=> (rsp_hit || !req_valid));

  // R9
  store_miss_no_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_req && !hit) |-> (way_wr == '0));

endmodule

// File: tb/sa2_cache_tb.sv
`timescale 1ns/1ps
module sa2_cache_tb;

  localparam int LAT = 3;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_write;
  logic [31:0] req_addr;
  logic [31:0] req_wdata;
  logic [31:0] rsp_rdata;
  logic        rsp_hit;
  logic        stall;
  logic        mem_rd_req;
  logic        mem_wr_req;
  logic [31:0] mem_addr;
  logic [31:0] mem_wdata;
  logic        mem_ack;
  logic [31:0] mem_rdata;

  int vectors;
  int miscompares;
  int rd_cnt;
  int wr_cnt;
  int lat_cnt;
  logic [31:0] last_rd_addr;
  logic [31:0] last_wr_addr;
  logic [31:0] mem [64];

  sa2_cache u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rsp_rdata (rsp_rdata),
    .rsp_hit   (rsp_hit),
    .stall     (stall),
    .mem_rd_req(mem_rd_req),
    .mem_wr_req(mem_wr_req),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ack   (mem_ack),
    .mem_rdata (mem_rdata)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [31:0] mval(int i);
    return (32'(i) * 32'h0001_0203) ^ 32'hC0DE_0000;
  endfunction

  // Lower memory: fixed latency, one-cycle ack.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_ack   <= 1'b0;
      lat_cnt   <= 0;
      mem_rdata <= '0;
    end else if ((mem_rd_req || mem_wr_req) && !mem_ack) begin
      if (lat_cnt == LAT - 1) begin
        lat_cnt <= 0;
        mem_ack <= 1'b1;
        if (mem_rd_req) begin
          mem_rdata    <= mem[mem_addr[7:2]];
          last_rd_addr <= mem_addr;
          rd_cnt       <= rd_cnt + 1;
        end else begin
          mem[mem_addr[7:2]] <= mem_wdata;
          last_wr_addr       <= mem_addr;
          wr_cnt             <= wr_cnt + 1;
        end
      end else begin
        lat_cnt <= lat_cnt + 1;
      end
    end else begin
      mem_ack <= 1'b0;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input logic w, input logic [31:0] a, input logic [31:0] d,
                        output logic first_hit, output logic [31:0] rd, output int cyc);
    @(negedge clk);
    req_valid = 1'b1;
    req_write = w;
    req_addr  = a;
    req_wdata = d;
    #1;
    first_hit = rsp_hit;
    cyc = 0;
    while (stall && cyc < 50) begin
      @(negedge clk);
      #1;
      cyc++;
    end
    rd = rsp_rdata;
    @(posedge clk);
    #1;
    req_valid = 1'b0;
    req_write = 1'b0;
  endtask

  // Load and check hit/miss and data; a miss must cost one memory read.
  task automatic load_chk(input string req, input logic [31:0] a, input logic exp_hit,
                          input logic [31:0] exp_data);
    logic h;
    logic [31:0] rd;
    int cyc;
    int r0;
    r0 = rd_cnt;
    access(1'b0, a, 32'h0, h, rd, cyc);
    check({req, " hit"}, {31'h0, h}, {31'h0, exp_hit});
    check({req, " data"}, rd, exp_data);
    check({req, " reads"}, 32'(rd_cnt - r0), exp_hit ? 32'd0 : 32'd1);
    if (!exp_hit) check({req, " miss cycles"}, 32'(cyc), 32'd5);
    else          check({req, " hit cycles"}, 32'(cyc), 32'd0);
  endtask

  task automatic store_do(input string req, input logic [31:0] a, input logic [31:0] d);
    logic h;
    logic [31:0] rd;
    int cyc;
    int w0;
    w0 = wr_cnt;
    access(1'b1, a, d, h, rd, cyc);
    check({req, " R7 writes"}, 32'(wr_cnt - w0), 32'd1);
    check({req, " R7 addr"}, last_wr_addr, a & 32'hFFFF_FFFC);
    check({req, " R7 data"}, mem[a[7:2]], d);
    check({req, " R7 cycles"}, 32'(cyc), 32'd4);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R1 idle stall", {31'h0, stall}, 32'h0);
    check("R1 idle rd_req", {31'h0, mem_rd_req}, 32'h0);
    check("R1 idle wr_req", {31'h0, mem_wr_req}, 32'h0);
    load_chk("R1 first load 0x04", 32'h04, 1'b0, mval(1));
    check("R4 read addr", last_rd_addr, 32'h04);
  endtask

  task automatic t_hit;
    load_chk("R3 reload 0x04", 32'h04, 1'b1, mval(1));
    load_chk("R2 offset 0x06", 32'h06, 1'b1, mval(1));
    load_chk("R2 offset 0x07", 32'h07, 1'b1, mval(1));
  endtask

  task automatic t_miss_align;
    load_chk("R4 miss 0x0B", 32'h0B, 1'b0, mval(2));
    check("R4 aligned addr", last_rd_addr, 32'h08);
  endtask

  task automatic t_conflict;
    load_chk("R5 miss 0x24", 32'h24, 1'b0, mval(9));
    for (int i = 0; i < 2; i++) begin
      load_chk("R5 alt 0x04", 32'h04, 1'b1, mval(1));
      load_chk("R5 alt 0x24", 32'h24, 1'b1, mval(9));
    end
  endtask

  task automatic t_lru;
    // 0x24 touched last, so 0x04 is the victim.
    load_chk("R6 miss 0x54", 32'h54, 1'b0, mval(21));
    load_chk("R6 keep 0x24", 32'h24, 1'b1, mval(9));
    load_chk("R6 evicted 0x04", 32'h04, 1'b0, mval(1));
    // 0x54 was least recent now and was replaced; 0x24 remains.
    load_chk("R6 keep 0x24 again", 32'h24, 1'b1, mval(9));
  endtask

  task automatic t_store_hit;
    // Set 1 holds 0x04 and 0x24, 0x24 most recent.
    store_do("R8 store hit 0x04", 32'h04, 32'hDEAD_0004);
    load_chk("R8 victim 0x54", 32'h54, 1'b0, mval(21));
    load_chk("R8 updated 0x04", 32'h04, 1'b1, 32'hDEAD_0004);
    load_chk("R8 evicted 0x24", 32'h24, 1'b0, mval(9));
  endtask

  task automatic t_store_miss;
    store_do("R9 store miss 0x70", 32'h70, 32'h1234_5670);
    load_chk("R9 no alloc 0x70", 32'h70, 1'b0, 32'h1234_5670);
  endtask

  task automatic t_sets;
    load_chk("R10 fill 0x0C", 32'h0C, 1'b0, mval(3));
    load_chk("R10 fill 0x4C", 32'h4C, 1'b0, mval(19));
    load_chk("R10 fill 0x8C", 32'h8C, 1'b0, mval(35));
    load_chk("R10 set1 0x04", 32'h04, 1'b1, 32'hDEAD_0004);
    load_chk("R10 set1 0x24", 32'h24, 1'b1, mval(9));
    load_chk("R10 set2 0x08", 32'h08, 1'b1, mval(2));
    load_chk("R10 set0 0x70", 32'h70, 1'b1, 32'h1234_5670);
  endtask

  initial begin
    vectors      = 0;
    miscompares  = 0;
    rd_cnt       = 0;
    wr_cnt       = 0;
    last_rd_addr = '0;
    last_wr_addr = '0;
    for (int i = 0; i < 64; i++) mem[i] = mval(i);
    rst_n     = 1'b0;
    req_valid = 1'b0;
    req_write = 1'b0;
    req_addr  = '0;
    req_wdata = '0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    t_reset();
    t_hit();
    t_miss_align();
    t_conflict();
    t_lru();
    t_store_hit();
    t_store_miss();
    t_sets();
    repeat (2) @(posedge clk);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    vectors++;
    miscompares++;
    $display("FAIL watchdog actual=%0d expected=done", 20000);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule